// File: doc/BRIEF.md
# Wake-up Line Selector

This block provides eight independent wake-up lines for a power controller. Each line selects one of three internal candidate signals, so twenty-four candidates feed the block in total. A per-line edge detector watches the chosen signal for a rising or a falling transition. A detected transition on an enabled line latches a sticky per-line flag. The flags of enabled lines are combined into a single wake request. That request is the wake source used to leave the deepest low-power states: the deep stop level, standby and shutdown.

Software reaches the block through a plain synchronous register port. There is one write strobe, a 2-bit address and a 32-bit write word, and the read data follows the address combinationally. Four registers exist: line enables, line polarities, source selects and flags. Software is expected to set the polarity and the source of a line before it enables that line. Edges are taken from the raw candidates before the multiplexer. Because of this, changing the configuration of a live line never produces an edge by itself.

Top module: `wkup_sel_top`

## Requirements
- R1: After the asynchronous reset, all four registers read 0 and wake_o is 0.
- R2: Register address 2 holds the source selects. Line n uses bits 2n+1:2n. Code s in 0..2 selects cand_i[3n+s]. Code 3 selects no source, so that line never flags.
- R3: Register address 1 holds the polarities, with bit n for line n. A value of 0 detects rising edges and 1 detects falling edges. An edge of the other direction is ignored.
- R4: Register address 0 holds the enables, with bit n for line n. An edge on a line whose enable bit is 0 does not set its flag.
- R5: Register address 3 holds the flags, with bit n for line n. A flag, once set, holds its value. Writing 1 to a flag bit clears it. Writing 0 to it has no effect.
- R6: wake_o is 1 exactly when some line has both its flag and its enable set. Clearing an enable bit leaves the flag, the polarity and the source select of that line unchanged.
- R7: Changing the source select or the polarity of an enabled line, while the candidate signals are steady, does not set a flag.
- R8: A candidate change applied before rising clock edge k sets the flag and wake_o after rising edge k+1, and not before it.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cand_i | input | 24 | Candidate wake signals; line n owns bits 3n+2:3n |
| we_i | input | 1 | Register write strobe |
| addr_i | input | 2 | Register address (0 enable, 1 polarity, 2 select, 3 flags) |
| wdata_i | input | 32 | Register write data |
| rdata_o | output | 32 | Read data for addr_i, unused bits 0 |
| wake_o | output | 1 | Combined wake request |

## Verification
The bench reconfigures an enabled line while its candidates hold steady. It changes the source select from a low candidate to a high one, and it flips the polarity over a high candidate. A detector that kept its history after the multiplexer would latch a false flag in both cases. The bench toggles the candidates that a line has not selected, toggles all three candidates under the unused select code, and toggles a disabled line. A wrong mux index, a missing enable gate or a decoded code 3 would each show up as a flag that should not be there. The bench also checks the following:
- It samples one cycle early, which catches a missing synchroniser stage.
- It applies a wrong-direction edge to a falling-polarity line.
- It writes zero to the flag register, which catches a flag register that clears on any write.
- It disables a flagged line, which catches a design that clears state on disable or leaves the wake request unmasked.

// File: rtl/wkup_sel_pkg.sv
package wkup_sel_pkg;
  typedef enum logic [1:0] {
    REG_EN   = 2'd0,
    REG_POL  = 2'd1,
    REG_SEL  = 2'd2,
    REG_FLAG = 2'd3
  } wkup_reg_e;
endpackage

// File: rtl/wkup_edge_bank.sv
module wkup_edge_bank #(
  parameter int unsigned N_SIG = 24
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [N_SIG-1:0] sig_i,
  output logic [N_SIG-1:0] rise_o,
  output logic [N_SIG-1:0] fall_o
);
  logic [N_SIG-1:0] smp_q, hist_q;

  // history kept per candidate, ahead of any mux, so reconfiguration is edge-free
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      smp_q  <= '0;
      hist_q <= '0;
    end else begin
      smp_q  <= sig_i;
      hist_q <= smp_q;
    end
  end

  assign rise_o = smp_q & ~hist_q;
  assign fall_o = ~smp_q & hist_q;
endmodule

// File: rtl/wkup_line.sv
module wkup_line #(
  parameter int unsigned N_SRC = 3,
  parameter int unsigned SEL_W = 2
) (
  input  logic [N_SRC-1:0] rise_i,
  input  logic [N_SRC-1:0] fall_i,
  input  logic [SEL_W-1:0] sel_i,
  input  logic             pol_i,
  input  logic             en_i,
  output logic             hit_o
);
  logic hit;

  always_comb begin
    hit = 1'b0;
    for (int s = 0; s < N_SRC; s++) begin
      if (sel_i == SEL_W'(s)) hit = pol_i ? fall_i[s] : rise_i[s];
    end
    hit_o = en_i & hit;
  end
endmodule

// File: rtl/wkup_sel_top.sv
module wkup_sel_top #(
  parameter int unsigned N_LINES = 8,
  parameter int unsigned N_SRC   = 3,
  parameter int unsigned SEL_W   = 2,
  parameter int unsigned DATA_W  = 32
) (
  input  logic                       clk_i,
  input  logic                       rst_ni,
  input  logic [N_LINES*N_SRC-1:0]   cand_i,
  input  logic                       we_i,
  input  logic [1:0]                 addr_i,
  input  logic [DATA_W-1:0]          wdata_i,
  output logic [DATA_W-1:0]          rdata_o,
  output logic                       wake_o
);
  import wkup_sel_pkg::*;

  localparam int unsigned N_CAND   = N_LINES * N_SRC;
  localparam int unsigned SEL_BITS = N_LINES * SEL_W;

  logic [N_LINES-1:0]  en_q, pol_q, flag_q, hit, clr;
  logic [SEL_BITS-1:0] sel_q;
  logic [N_CAND-1:0]   rise, fall;

  wkup_edge_bank #(.N_SIG(N_CAND)) u_edges (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .sig_i  (cand_i),
    .rise_o (rise),
    .fall_o (fall)
  );

  for (genvar l = 0; l < N_LINES; l++) begin : g_line
    wkup_line #(.N_SRC(N_SRC), .SEL_W(SEL_W)) u_line (
      .rise_i (rise[l*N_SRC +: N_SRC]),
      .fall_i (fall[l*N_SRC +: N_SRC]),
      .sel_i  (sel_q[l*SEL_W +: SEL_W]),
      .pol_i  (pol_q[l]),
      .en_i   (en_q[l]),
      .hit_o  (hit[l])
    );
  end

  assign clr = (we_i && addr_i == REG_FLAG) ? wdata_i[N_LINES-1:0] : '0;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      en_q   <= '0;
      pol_q  <= '0;
      sel_q  <= '0;
      flag_q <= '0;
    end else begin
      if (we_i && addr_i == REG_EN)  en_q  <= wdata_i[N_LINES-1:0];
      if (we_i && addr_i == REG_POL) pol_q <= wdata_i[N_LINES-1:0];
      if (we_i && addr_i == REG_SEL) sel_q <= wdata_i[SEL_BITS-1:0];
      // a new edge wins over a same-cycle clear
      flag_q <= (flag_q & ~clr) | hit;
    end
  end

  always_comb begin
    rdata_o = '0;
    unique case (addr_i)
      REG_EN:   rdata_o[N_LINES-1:0]  = en_q;
      REG_POL:  rdata_o[N_LINES-1:0]  = pol_q;
      REG_SEL:  rdata_o[SEL_BITS-1:0] = sel_q;
      default:  rdata_o[N_LINES-1:0]  = flag_q;
    endcase
  end

  assign wake_o = |(flag_q & en_q);
endmodule

// File: rtl/wkup_sel_chk.sv
module wkup_sel_chk #(
  parameter int unsigned N_LINES  = 8,
  parameter int unsigned SEL_BITS = 16
) (
  input logic                clk_i,
  input logic                rst_ni,
  input logic                we_i,
  input logic [1:0]          addr_i,
  input logic [N_LINES-1:0]  en_q,
  input logic [N_LINES-1:0]  pol_q,
  input logic [SEL_BITS-1:0] sel_q,
  input logic [N_LINES-1:0]  flag_q,
  input logic                wake_o
);
  p_cfg_hold_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !we_i |=> ($stable(en_q) && $stable(pol_q) && $stable(sel_q)));

  p_flag_needs_en_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |=> ((flag_q & ~$past(flag_q) & ~$past(en_q)) == '0));

  p_flag_w1c_only_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |=> (((~flag_q & $past(flag_q)) == '0) || $past(we_i && addr_i == 2'd3)));

  p_disable_keeps_cfg_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (we_i && addr_i == 2'd0) |=> ($stable(pol_q) && $stable(sel_q) && $stable(flag_q)));

  p_wake_masked_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wake_o |-> ((flag_q & en_q) != '0));
endmodule

bind wkup_sel_top wkup_sel_chk #(.N_LINES(N_LINES), .SEL_BITS(SEL_BITS)) u_chk (
  .clk_i  (clk_i),
  .rst_ni (rst_ni),
  .we_i   (we_i),
  .addr_i (addr_i),
  .en_q   (en_q),
  .pol_q  (pol_q),
  .sel_q  (sel_q),
  .flag_q (flag_q),
  .wake_o (wake_o)
);

// File: tb/wkup_sel_top_tb_top.sv
module wkup_sel_top_tb_top;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic [23:0] cand_i = '0;
  logic        we_i = 1'b0;
  logic [1:0]  addr_i = 2'd0;
  logic [31:0] wdata_i = '0;
  logic [31:0] rdata_o;
  logic        wake_o;

  int n_chk = 0;
  int n_fail = 0;
  bit finished = 1'b0;

  typedef struct {
    logic [1:0]  addr;
    logic [31:0] data;
    logic        wake;
    string       tag;
  } exp_t;
  exp_t sb[$];

  always #10 clk_i = ~clk_i;

  wkup_sel_top dut_i (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .cand_i  (cand_i),
    .we_i    (we_i),
    .addr_i  (addr_i),
    .wdata_i (wdata_i),
    .rdata_o (rdata_o),
    .wake_o  (wake_o)
  );

  // monitor: pops expectations, reads the port, compares
  initial begin
    exp_t it;
    forever begin
      wait (sb.size() != 0);
      it = sb.pop_front();
      addr_i = it.addr;
      #1;
      n_chk++;
      if (rdata_o !== it.data || wake_o !== it.wake) begin
        n_fail++;
        $display("FAIL %s: rdata=%h wake=%b expected rdata=%h wake=%b",
                 it.tag, rdata_o, wake_o, it.data, it.wake);
      end
    end
  end

  task automatic expect_rd(input logic [1:0] a, input logic [31:0] d, input logic w, input string t);
    exp_t it;
    it.addr = a; it.data = d; it.wake = w; it.tag = t;
    sb.push_back(it);
    wait (sb.size() == 0);
    #2;
  endtask

  task automatic wr(input logic [1:0] a, input logic [31:0] d);
    @(negedge clk_i);
    we_i = 1'b1; addr_i = a; wdata_i = d;
    @(negedge clk_i);
    we_i = 1'b0;
  endtask

  task automatic settle();
    @(negedge clk_i);
    @(negedge clk_i);
  endtask

  initial begin
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    @(negedge clk_i);
    expect_rd(2'd0, 32'h0, 1'b0, "R1 enable after reset");
    expect_rd(2'd1, 32'h0, 1'b0, "R1 polarity after reset");
    expect_rd(2'd2, 32'h0, 1'b0, "R1 select after reset");
    expect_rd(2'd3, 32'h0, 1'b0, "R1 flags after reset");

    wr(2'd2, 32'h10);             // line2 code1
    wr(2'd1, 32'h08);             // line3 falling
    expect_rd(2'd2, 32'h10, 1'b0, "R2 select readback");
    expect_rd(2'd1, 32'h08, 1'b0, "R3 polarity readback");
    @(negedge clk_i); cand_i[9] = 1'b1;
    settle();
    wr(2'd0, 32'h0C);
    expect_rd(2'd0, 32'h0C, 1'b0, "R4 enable readback");

    @(negedge clk_i); cand_i[6] = 1'b1;   // unselected candidate of line2
    settle();
    expect_rd(2'd3, 32'h0, 1'b0, "R2 unselected candidate ignored");

    @(negedge clk_i); cand_i[7] = 1'b1;   // selected candidate of line2
    @(negedge clk_i);
    expect_rd(2'd3, 32'h0, 1'b0, "R8 flag not yet set after one edge");
    @(negedge clk_i);
    expect_rd(2'd3, 32'h04, 1'b1, "R8 flag set after second edge, R2 selection");

    @(negedge clk_i); cand_i[9] = 1'b0;   // falling on line3
    settle();
    expect_rd(2'd3, 32'h0C, 1'b1, "R3 falling edge detected");

    wr(2'd3, 32'h08);
    expect_rd(2'd3, 32'h04, 1'b1, "R5 write one clears");
    wr(2'd3, 32'h00);
    expect_rd(2'd3, 32'h04, 1'b1, "R5 write zero no effect");

    @(negedge clk_i); cand_i[9] = 1'b1;   // rising on falling-polarity line
    settle();
    expect_rd(2'd3, 32'h04, 1'b1, "R3 rising edge ignored on falling line");

    @(negedge clk_i); cand_i[15] = 1'b1;  // line5 disabled
    settle();
    expect_rd(2'd3, 32'h04, 1'b1, "R4 disabled line ignored");

    wr(2'd3, 32'h04);
    expect_rd(2'd3, 32'h00, 1'b0, "R5 clear line2");
    @(negedge clk_i); cand_i[9] = 1'b0;
    settle();
    expect_rd(2'd3, 32'h08, 1'b1, "R6 line3 flagged");
    wr(2'd0, 32'h04);
    expect_rd(2'd3, 32'h08, 1'b0, "R6 disable masks wake, keeps flag");
    expect_rd(2'd1, 32'h08, 1'b0, "R6 disable keeps polarity");
    expect_rd(2'd2, 32'h10, 1'b0, "R6 disable keeps select");
    wr(2'd0, 32'h0C);
    expect_rd(2'd3, 32'h08, 1'b1, "R6 re-enable restores wake");
    wr(2'd3, 32'hFF);
    expect_rd(2'd3, 32'h00, 1'b0, "R5 clear all");

    wr(2'd2, 32'h310);            // line4 code3
    wr(2'd0, 32'h1C);
    @(negedge clk_i); cand_i[14:12] = 3'b111;
    settle();
    expect_rd(2'd3, 32'h00, 1'b0, "R2 code 3 selects nothing");

    @(negedge clk_i); cand_i[1] = 1'b1;   // line0: cand0=0, cand1=1
    settle();
    wr(2'd0, 32'h1D);
    wr(2'd2, 32'h311);            // switch line0 to the high candidate
    settle();
    expect_rd(2'd3, 32'h00, 1'b0, "R7 select change no false edge");
    wr(2'd1, 32'h09);             // flip line0 to falling over a high level
    settle();
    expect_rd(2'd3, 32'h00, 1'b0, "R7 polarity change no false edge");
    @(negedge clk_i); cand_i[1] = 1'b0;
    settle();
    expect_rd(2'd3, 32'h01, 1'b1, "R7 genuine edge after reconfiguration");

    finished = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk_i);
    if (!finished) begin
      n_fail++;
      $display("FAIL watchdog (R1..R8 run): actual=hung expected=complete");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end
endmodule